// File: doc/BRIEF.md
# Oversampled Pulse Clock Recovery

This block recovers bit timing from a serial line on which every 1 bit shows up as a single-cycle rise event. The event input has already been synchronized and edge-detected. The block runs at eight times the nominal bit rate. It walks a sixteen-position phase counter split into two halves. The first half means "the current cell began with an event", so the bit is a 1. The second half means "the cell passed with no event where one was due", so the bit is a 0. The recovered bit value lives only in that half selection. No separate data register holds it.

Each cell produces one registered strobe, `tick`, in the cycle after the counter reaches the capture point of the cell. The capture point is the first slot of a 1 cell or the second slot of a 0 cell. A downstream stage captures `bitOne` on that strobe. An enable input, `mask`, gates the strobe.

An event near the expected end of a 1 cell, or anywhere in a 0 cell, pulls the phase back to the start of a 1 cell. This lets the counter follow cells that are stretched or shrunk by one slot. Events early in a 1 cell are treated as noise and ignored.

Top module: `pulse_clk_recovery`

## Requirements
- R1: A synchronous `rst` puts the counter in the first slot of the one half. After it, `bitOne`=1, `slotIdx`=0 and `tick`=0.
- R2: With `line` low, the slot index steps up by one each clock within a half. From slot 7 of either half the counter moves to slot 0 of the zero half, so `bitOne`=0 and `slotIdx`=0.
- R3: An event while in slot 6 or 7 of the one half sends the counter to slot 0 of the one half on the next clock.
- R4: An event while in any slot (0 to 7) of the zero half sends the counter to slot 0 of the one half on the next clock.
- R5: An event while in slots 0 to 5 of the one half has no effect. The counter advances by one exactly as with `line` low.
- R6: `tick` is a register. It is 1 in a cycle exactly when `mask` was 1 on the previous clock and the counter has just entered one-half slot 0 or zero-half slot 1. So `tick` is only ever high at those two positions.
- R7: While `mask` is 0 on a clock edge, `tick` is 0 in the following cycle.
- R8: `bitOne` is 1 while the counter is in the one half and 0 in the zero half. `slotIdx` gives the position (0 to 7) within the half.
- R9: Consider a 1 cell whose following event comes 7, 8 or 9 clocks after its own event, and a 0 cell that is 8 clocks long. A stream of such cells, once synchronized by an event, produces exactly one `tick` per cell. The `bitOne` values seen at those ticks equal the sent bit sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at eight times the nominal bit rate |
| rst | input | 1 | Synchronous reset, active high |
| line | input | 1 | One-cycle rise event from the line |
| mask | input | 1 | Enable for the capture strobe |
| tick | output | 1 | Registered capture strobe, one per cell |
| bitOne | output | 1 | Recovered bit: 1 in the one half, 0 in the zero half |
| slotIdx | output | 3 | Slot position within the current half |

## Verification
A behavioural model is compared with the outputs on every clock. The stimulus comes in several patterns:

- A quiet line checks free-running advance and the wrap into the zero half.
- Held-high events across the early one-half slots show whether noise is ignored.
- Single events placed in every late one-half slot and every zero-half slot separate the resync windows from the ignore window.
- A cell stream with 7, 8 and 9 clock spacing mixed with empty cells shows that tolerance to stretched and shrunk cells keeps the decoded sequence intact.
- Toggling `mask` and random line activity separate strobe gating from phase tracking.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  // Strobes from phase control to the phase datapath
  typedef struct packed {
    logic resync;    // next state is one-half slot 0
    logic toZero;    // next state is zero-half slot 0
    logic tickNext;  // next state is a capture position
  } pcrStrobe_t;

endpackage

// File: rtl/pcr_phase_ctl.sv
module pcr_phase_ctl
  import pcr_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int EARLY_WIN = 2,
  localparam int PH_W     = $clog2(SLOTS)
) (
  input  logic            line,
  input  logic            inZero,
  input  logic [PH_W-1:0] slot,
  output pcrStrobe_t      strobe
);

  localparam logic [PH_W-1:0] WIN_START = PH_W'(SLOTS - EARLY_WIN);
  localparam logic [PH_W-1:0] SLOT_MAX  = PH_W'(SLOTS - 1);

  logic inLateWin;
  logic doResync;
  logic atLast;

  always_comb begin
    inLateWin = !inZero && (slot >= WIN_START);
    // an event in the zero half always resyncs; in the one half only late
    doResync  = line && (inZero || inLateWin);
    atLast    = (slot == SLOT_MAX);
    strobe.resync   = doResync;
    strobe.toZero   = !doResync && atLast;
    strobe.tickNext = doResync || (inZero && slot == '0 && !line);
  end

endmodule

// File: rtl/pcr_phase_path.sv
module pcr_phase_path
  import pcr_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int PH_W = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mask,
  input  pcrStrobe_t      strobe,
  output logic            inZero,
  output logic [PH_W-1:0] slot,
  output logic            tick
);

  logic            nextZero;
  logic [PH_W-1:0] nextSlot;

  always_comb begin
    if (strobe.resync) begin
      nextZero = 1'b0;
      nextSlot = '0;
    end else if (strobe.toZero) begin
      nextZero = 1'b1;
      nextSlot = '0;
    end else begin
      nextZero = inZero;
      nextSlot = slot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inZero <= 1'b0;
      slot   <= '0;
      tick   <= 1'b0;
    end else begin
      inZero <= nextZero;
      slot   <= nextSlot;
      tick   <= mask && strobe.tickNext;
    end
  end

  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !mask |=> !tick);

  // R6
  tick_place_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> ((!inZero && slot == '0) || (inZero && slot == PH_W'(1))));

endmodule

// File: rtl/pulse_clk_recovery.sv
module pulse_clk_recovery
  import pcr_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int EARLY_WIN = 2,
  localparam int PH_W     = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line,
  input  logic            mask,
  output logic            tick,
  output logic            bitOne,
  output logic [PH_W-1:0] slotIdx
);

  localparam logic [PH_W-1:0] WIN_START = PH_W'(SLOTS - EARLY_WIN);
  localparam logic [PH_W-1:0] SLOT_MAX  = PH_W'(SLOTS - 1);

  pcrStrobe_t      strobe;
  logic            inZero;
  logic [PH_W-1:0] slot;

  pcr_phase_ctl #(.SLOTS(SLOTS), .EARLY_WIN(EARLY_WIN)) u_ctl (
    .line   (line),
    .inZero (inZero),
    .slot   (slot),
    .strobe (strobe)
  );

  pcr_phase_path #(.SLOTS(SLOTS)) u_path (
    .clk    (clk),
    .rst    (rst),
    .mask   (mask),
    .strobe (strobe),
    .inZero (inZero),
    .slot   (slot),
    .tick   (tick)
  );

  assign bitOne  = !inZero;
  assign slotIdx = slot;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (bitOne && slotIdx == '0 && !tick));

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!line && slotIdx == SLOT_MAX) |=> (!bitOne && slotIdx == '0));

  // R3
  late_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (line && bitOne && slotIdx >= WIN_START) |=> (bitOne && slotIdx == '0));

  // R4
  zero_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (line && !bitOne) |=> (bitOne && slotIdx == '0));

  // R5
  early_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (line && bitOne && slotIdx < WIN_START) |=>
      (bitOne && slotIdx == $past(slotIdx) + 1'b1));

endmodule

// File: tb/sim_pulse_clk_recovery.sv
module sim_pulse_clk_recovery;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line = 1'b0;
  logic       mask = 1'b1;
  logic       tick;
  logic       bitOne;
  logic [2:0] slotIdx;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit armed = 0;
  bit collect = 0;
  bit done = 0;
  string curReq = "R1";

  int mState = 0;
  bit mTick = 0;
  bit sentQ[$];
  bit gotQ[$];

  pulse_clk_recovery u0 (
    .clk(clk), .rst(rst), .line(line), .mask(mask),
    .tick(tick), .bitOne(bitOne), .slotIdx(slotIdx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: state 0..7 one half, 8..15 zero half
  always @(posedge clk) begin
    int nxt;
    if (rst) begin
      mState = 0;
      mTick = 0;
    end else begin
      if (line && (mState >= 8 || mState >= 6)) nxt = 0;
      else if (mState % 8 == 7) nxt = 8;
      else nxt = mState + 1;
      mTick = mask && (nxt == 0 || nxt == 9);
      mState = nxt;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (armed) begin
      check(curReq == "R7" ? "R7" : (curReq == "R1" ? "R1" : "R6"), "tick", tick, mTick);
      check("R8", "bitOne", bitOne, (mState < 8) ? 1 : 0);
      check(curReq == "R1" ? "R1" : "R2", "slotIdx", slotIdx, mState % 8);
    end
    if (collect && tick) gotQ.push_back(bitOne);
  end

  task automatic step(input bit l);
    line = l;
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    step(0);
    step(0);
    rst = 1'b0;
  endtask

  task automatic sendBit(input bit b, input int width);
    if (b) begin
      step(1);
      for (int k = 1; k < width; k++) step(0);
    end else begin
      for (int k = 0; k < 8; k++) step(0);
    end
  endtask

  initial begin
    @(negedge clk);
    doReset();
    armed = 1;
    // R1 explicit reset state
    check("R1", "reset tick", tick, 0);
    check("R1", "reset bitOne", bitOne, 1);
    check("R1", "reset slotIdx", slotIdx, 0);

    // R2 quiet line: advance and wrap
    curReq = "R2";
    for (int k = 0; k < 20; k++) step(0);

    // R5 events held across one-half slots 0..5
    curReq = "R5";
    doReset();
    for (int k = 0; k < 6; k++) step(1);
    step(0);
    check("R5", "slot after ignored events", slotIdx, 7);
    check("R5", "half after ignored events", bitOne, 1);

    // R3 events in one6 and one7
    curReq = "R3";
    for (int p = 6; p < 8; p++) begin
      doReset();
      for (int k = 0; k < p; k++) step(0);
      step(1);
      check("R3", "resync slot", slotIdx, 0);
      check("R3", "resync half", bitOne, 1);
    end

    // R4 events in every zero-half slot
    curReq = "R4";
    for (int p = 0; p < 8; p++) begin
      doReset();
      for (int k = 0; k < 8 + p; k++) step(0);
      step(1);
      check("R4", "resync slot", slotIdx, 0);
      check("R4", "resync half", bitOne, 1);
    end

    // R7 mask held low through several capture points
    curReq = "R7";
    doReset();
    mask = 0;
    for (int k = 0; k < 30; k++) step((k % 9) == 4);
    mask = 1;
    curReq = "R6";
    for (int k = 0; k < 10; k++) step(0);

    // R9 stream decode with 7/8/9 clock spacing
    curReq = "R9";
    doReset();
    for (int k = 0; k < 10; k++) step(0);
    collect = 1;
    sentQ.push_back(1);
    sendBit(1, 8);
    for (int i = 0; i < 40; i++) begin
      bit b;
      b = ((i * 7) % 5) < 3;
      if (i == 39) b = 0;
      sentQ.push_back(b);
      sendBit(b, 7 + (i % 3));
    end
    collect = 0;
    check("R9", "tick count", gotQ.size(), sentQ.size());
    for (int i = 0; i < sentQ.size() && i < gotQ.size(); i++)
      check("R9", "decoded bit", gotQ[i], sentQ[i]);

    // R6 random activity with mask toggling
    curReq = "R6";
    for (int k = 0; k < 400; k++) begin
      mask = ($urandom % 4) != 0;
      step(($urandom % 6) == 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=finish", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule